// File: doc/BRIEF.md
# Peripheral pin remapping crossbar

This block is the routing fabric between the remappable I/O pins of a chip and the signals of its on-chip peripherals. Each peripheral input owns a 6-bit select register that names the pin driving it. Each output-capable pin owns a select field that names the peripheral output function driving it. The output field also sets the pin's output enable. A pin with no function selected stays under ordinary port control.

The pin set is sparse. The code space covers 64 pins, and 46 pin positions exist. The upper 14 of those positions are input-only and have no output field. Each position is marked present or absent by a mask parameter, and by default pins 31 and 39 are absent. An input code that points past pin 45 or at an absent pin is invalid. The peripheral input it selects is then held at its own inactive level. Output fields of absent pins are not stored at all.

Each register has one select, so two pins cannot contend for one peripheral input and two functions cannot contend for one pin. Fan-out is allowed in both directions. Writes come from a simple register port and take effect only while an external write-enable, driven by the lock policy outside this block, is high.

Top module: `pps_crossbar`

## Requirements
- R1: After reset every input select reads 63, every output select reads 0, every `periph_in` bit sits at its `IN_IDLE` level (default 8'hA5), and every `pin_oe` is 0.
- R2: An input select code c with c <= 45 whose pin is present routes `pin_in[c]` to that peripheral input, combinationally.
- R3: An input select code above 45, or one naming an absent pin (31 or 39 by default), holds that peripheral input at `IN_IDLE[i]`.
- R4: Several peripheral inputs may select the same pin, and several pins may select the same function; each copy follows its source.
- R5: For an output select code k: k = 0 gives `pin_oe` = 0 and `pin_out` = 0; 1 <= k <= 12 gives `pin_oe` = 1 and `pin_out` = `func_out[k-1]`; 13..15 give `pin_oe` = 0 and `pin_out` = 0.
- R6: The output field of an absent pin ignores writes, always reads 0 and keeps `pin_oe` at 0.
- R7: A register changes only on a clock edge where `bus_wr_stb` and `bus_wr_en` are both 1, and the new value is seen on `bus_rdata` and on the routing from the following cycle.
- R8: Address i (0..7) is input select i (6 bits). Address 8+p (8..39) is the output select of pin p, which keeps `bus_wdata[3:0]` and reads with bits 5:4 as 0. Addresses 40..63 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr_stb | input | 1 | Register write strobe |
| bus_wr_en | input | 1 | External write permission; writes are dropped while low |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data for `bus_addr` (combinational) |
| pin_in | input | 46 | Levels seen on the remappable pins |
| periph_in | output | 8 | Routed peripheral input signals |
| func_out | input | 12 | Peripheral output functions, code k drives bit k-1 |
| pin_out | output | 32 | Data for the output-capable pins |
| pin_oe | output | 32 | Output enable for the output-capable pins |

## Verification
A wrong select register shows up at once in two places. Its read-back on `bus_rdata` is wrong in the cycle after the write. Its peripheral input or pin is routed from the wrong source for as long as the register holds the value. A validity decode that is off by one near code 45 or 12, or that ignores the presence mask, makes a peripheral input take a live pin value where its idle level belongs, or turns on an output enable that should stay off. The bench drives fresh random pin and function levels for every routing check, so such a fault is caught on the first pattern where the two candidate sources differ.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int IN_SEL_W = 6;
  localparam logic [IN_SEL_W-1:0] IN_UNMAPPED = '1;

  function automatic logic in_code_ok(input logic [IN_SEL_W-1:0] code,
                                      input int unsigned npins,
                                      input logic [63:0] present);
    return (32'(code) < npins) && present[code];
  endfunction
endpackage

// File: rtl/pps_regfile.sv
module pps_regfile
  import pps_pkg::*;
#(
  parameter int NUM_PI       = 8,
  parameter int NUM_OUT_PINS = 32,
  parameter int OUT_SEL_W    = 4,
  parameter int ADDR_W       = 6,
  parameter logic [63:0] PIN_PRESENT = 64'h0000_3F7F_7FFF_FFFF
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_stb,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [IN_SEL_W-1:0]                   wdata,
  output logic [IN_SEL_W-1:0]                   rdata,
  output logic [NUM_PI-1:0][IN_SEL_W-1:0]       in_sel,
  output logic [NUM_OUT_PINS-1:0][OUT_SEL_W-1:0] out_sel
);
  localparam int OUT_BASE = NUM_PI;
  localparam int REG_END  = NUM_PI + NUM_OUT_PINS;

  logic wr_go;
  assign wr_go = wr_stb & wr_en;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PI; gi++) begin : g_in
      logic                ld;
      logic [IN_SEL_W-1:0] nxt;
      logic [IN_SEL_W-1:0] q;
      always_comb begin
        ld  = wr_go && (32'(addr) == gi);
        nxt = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= IN_UNMAPPED;
        else if (ld) q <= nxt;
      end
      assign in_sel[gi] = q;
    end

    for (gi = 0; gi < NUM_OUT_PINS; gi++) begin : g_out
      if (PIN_PRESENT[gi]) begin : g_present
        logic                 ld;
        logic [OUT_SEL_W-1:0] nxt;
        logic [OUT_SEL_W-1:0] q;
        always_comb begin
          ld  = wr_go && (32'(addr) == OUT_BASE + gi);
          nxt = wdata[OUT_SEL_W-1:0];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  q <= '0;
          else if (ld) q <= nxt;
        end
        assign out_sel[gi] = q;
      end else begin : g_absent
        assign out_sel[gi] = '0;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PI; i++)
      if (32'(addr) == i) rdata = in_sel[i];
    for (int p = 0; p < NUM_OUT_PINS; p++)
      if (32'(addr) == OUT_BASE + p) rdata = IN_SEL_W'(out_sel[p]);
    if (32'(addr) >= REG_END) rdata = '0;
  end
endmodule

// File: rtl/pps_in_mux.sv
module pps_in_mux
  import pps_pkg::*;
#(
  parameter int NUM_PI   = 8,
  parameter int NUM_PINS = 46,
  parameter logic [63:0] PIN_PRESENT = 64'h0000_3F7F_7FFF_FFFF,
  parameter logic [NUM_PI-1:0] IN_IDLE = 8'hA5
) (
  input  logic [NUM_PI-1:0][IN_SEL_W-1:0] in_sel,
  input  logic [NUM_PINS-1:0]             pin_in,
  output logic [NUM_PI-1:0]               periph_in
);
  localparam int CODE_SPACE = 1 << IN_SEL_W;

  logic [CODE_SPACE-1:0] pin_ext;
  assign pin_ext = CODE_SPACE'(pin_in);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PI; gi++) begin : g_sel
      logic ok;
      always_comb begin
        ok = in_code_ok(in_sel[gi], NUM_PINS, PIN_PRESENT);
        periph_in[gi] = ok ? pin_ext[in_sel[gi]] : IN_IDLE[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/pps_out_mux.sv
module pps_out_mux #(
  parameter int NUM_OUT_PINS = 32,
  parameter int NUM_FUNCS    = 12,
  parameter int OUT_SEL_W    = 4
) (
  input  logic [NUM_OUT_PINS-1:0][OUT_SEL_W-1:0] out_sel,
  input  logic [NUM_FUNCS-1:0]                   func_out,
  output logic [NUM_OUT_PINS-1:0]                pin_out,
  output logic [NUM_OUT_PINS-1:0]                pin_oe
);
  localparam int CODE_SPACE = 1 << OUT_SEL_W;

  // code 0 and codes past the last function land on zero padding
  logic [CODE_SPACE-1:0] func_ext;
  assign func_ext = CODE_SPACE'({func_out, 1'b0});

  genvar gp;
  generate
    for (gp = 0; gp < NUM_OUT_PINS; gp++) begin : g_pin
      always_comb begin
        pin_oe[gp]  = (out_sel[gp] != '0) && (32'(out_sel[gp]) <= NUM_FUNCS);
        pin_out[gp] = func_ext[out_sel[gp]];
      end
    end
  endgenerate
endmodule

// File: rtl/pps_crossbar.sv
module pps_crossbar
  import pps_pkg::*;
#(
  parameter int NUM_PINS     = 46,
  parameter int NUM_OUT_PINS = 32,
  parameter int NUM_PI       = 8,
  parameter int NUM_FUNCS    = 12,
  parameter int ADDR_W       = 6,
  parameter logic [63:0] PIN_PRESENT = 64'h0000_3F7F_7FFF_FFFF,
  parameter logic [NUM_PI-1:0] IN_IDLE = 8'hA5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr_stb,
  input  logic                    bus_wr_en,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [IN_SEL_W-1:0]     bus_wdata,
  output logic [IN_SEL_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]     pin_in,
  output logic [NUM_PI-1:0]       periph_in,
  input  logic [NUM_FUNCS-1:0]    func_out,
  output logic [NUM_OUT_PINS-1:0] pin_out,
  output logic [NUM_OUT_PINS-1:0] pin_oe
);
  localparam int OUT_SEL_W = $clog2(NUM_FUNCS + 1);

  logic rst_meta;
  logic rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  logic [NUM_PI-1:0][IN_SEL_W-1:0]        in_sel;
  logic [NUM_OUT_PINS-1:0][OUT_SEL_W-1:0] out_sel;

  pps_regfile #(
    .NUM_PI(NUM_PI), .NUM_OUT_PINS(NUM_OUT_PINS), .OUT_SEL_W(OUT_SEL_W),
    .ADDR_W(ADDR_W), .PIN_PRESENT(PIN_PRESENT)
  ) u_regs (
    .clk(clk), .rst_n(rst_ok), .wr_stb(bus_wr_stb), .wr_en(bus_wr_en),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .in_sel(in_sel), .out_sel(out_sel)
  );

  pps_in_mux #(
    .NUM_PI(NUM_PI), .NUM_PINS(NUM_PINS), .PIN_PRESENT(PIN_PRESENT),
    .IN_IDLE(IN_IDLE)
  ) u_in (
    .in_sel(in_sel), .pin_in(pin_in), .periph_in(periph_in)
  );

  pps_out_mux #(
    .NUM_OUT_PINS(NUM_OUT_PINS), .NUM_FUNCS(NUM_FUNCS), .OUT_SEL_W(OUT_SEL_W)
  ) u_out (
    .out_sel(out_sel), .func_out(func_out), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/pps_crossbar_chk.sv
module pps_crossbar_chk
  import pps_pkg::*;
#(
  parameter int NUM_PINS     = 46,
  parameter int NUM_OUT_PINS = 32,
  parameter int NUM_PI       = 8,
  parameter int OUT_SEL_W    = 4,
  parameter logic [63:0] PIN_PRESENT = 64'h0000_3F7F_7FFF_FFFF,
  parameter logic [NUM_PI-1:0] IN_IDLE = 8'hA5
) (
  input logic                                   clk,
  input logic                                   rst_ok,
  input logic                                   bus_wr_stb,
  input logic                                   bus_wr_en,
  input logic [NUM_PINS-1:0]                    pin_in,
  input logic [NUM_PI-1:0]                      periph_in,
  input logic [NUM_OUT_PINS-1:0]                pin_out,
  input logic [NUM_OUT_PINS-1:0]                pin_oe,
  input logic [NUM_PI-1:0][IN_SEL_W-1:0]        in_sel,
  input logic [NUM_OUT_PINS-1:0][OUT_SEL_W-1:0] out_sel
);
  logic [63:0] pins64;
  assign pins64 = 64'(pin_in);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PI; gi++) begin : g_in
      assert_route_R2: assert property (@(posedge clk) disable iff (!rst_ok)
        (32'(in_sel[gi]) < NUM_PINS && PIN_PRESENT[in_sel[gi]])
          |-> periph_in[gi] == pins64[in_sel[gi]]);
      assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_ok)
        (32'(in_sel[gi]) >= NUM_PINS || !PIN_PRESENT[in_sel[gi]])
          |-> periph_in[gi] == IN_IDLE[gi]);
    end
    for (gi = 0; gi < NUM_OUT_PINS; gi++) begin : g_out
      assert_unsel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_ok)
        (out_sel[gi] == '0) |-> (!pin_oe[gi] && !pin_out[gi]));
      if (!PIN_PRESENT[gi]) begin : g_abs
        assert_absent_off_R6: assert property (@(posedge clk) disable iff (!rst_ok)
          bus_wr_stb |=> (!pin_oe[gi] && out_sel[gi] == '0));
      end
    end
  endgenerate

  assert_gated_write_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr_stb && !bus_wr_en) |=> ($stable(in_sel) && $stable(out_sel)));
endmodule

bind pps_crossbar pps_crossbar_chk #(
  .NUM_PINS(NUM_PINS), .NUM_OUT_PINS(NUM_OUT_PINS), .NUM_PI(NUM_PI),
  .OUT_SEL_W(OUT_SEL_W), .PIN_PRESENT(PIN_PRESENT), .IN_IDLE(IN_IDLE)
) u_chk (
  .clk(clk), .rst_ok(rst_ok), .bus_wr_stb(bus_wr_stb), .bus_wr_en(bus_wr_en),
  .pin_in(pin_in), .periph_in(periph_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .in_sel(in_sel), .out_sel(out_sel)
);

// File: tb/pps_crossbar_test.sv
module pps_crossbar_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PRESENT = 64'h0000_3F7F_7FFF_FFFF; // pins 31, 39 absent
  localparam logic [7:0]  IDLE    = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_stb, bus_wr_en;
  logic [5:0]  bus_addr, bus_wdata, bus_rdata;
  logic [45:0] pin_in;
  logic [7:0]  periph_in;
  logic [11:0] func_out;
  logic [31:0] pin_out, pin_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_crossbar uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_stb(bus_wr_stb), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .periph_in(periph_in), .func_out(func_out),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [5:0] addr;
    logic [5:0] data;
    logic [5:0] exp;
  } vec_t;

  // write addr <- data, then read back exp
  localparam vec_t VECS [17] = '{
    '{4'd8, 6'd0,  6'd3,  6'd3 },   // R8 input 0 <- pin 3
    '{4'd4, 6'd1,  6'd3,  6'd3 },   // R4 input 1 also <- pin 3
    '{4'd2, 6'd2,  6'd45, 6'd45},   // R2 last legal code
    '{4'd3, 6'd3,  6'd46, 6'd46},   // R3 first illegal code
    '{4'd3, 6'd4,  6'd31, 6'd31},   // R3 absent pin
    '{4'd3, 6'd5,  6'd39, 6'd39},   // R3 absent input-only pin
    '{4'd2, 6'd6,  6'd32, 6'd32},   // R2 input-only pin
    '{4'd2, 6'd7,  6'd0,  6'd0 },   // R2 pin 0
    '{4'd5, 6'd8,  6'd1,  6'd1 },   // R5 pin 0 <- func 1
    '{4'd4, 6'd9,  6'd1,  6'd1 },   // R4 pin 1 <- func 1
    '{4'd5, 6'd10, 6'd12, 6'd12},   // R5 last function
    '{4'd5, 6'd11, 6'd13, 6'd13},   // R5 code past last function
    '{4'd6, 6'd39, 6'd5,  6'd0 },   // R6 absent pin 31
    '{4'd8, 6'd38, 6'h27, 6'd7 },   // R8 upper data bits dropped
    '{4'd8, 6'd40, 6'd5,  6'd0 },   // R8 unmapped address
    '{4'd8, 6'd63, 6'd1,  6'd0 },   // R8 top address
    '{4'd5, 6'd12, 6'd15, 6'd15}    // R5 highest code
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [5:0] m_in  [8];
  logic [3:0] m_out [32];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [5:0] d, input logic en);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_stb = 1'b1; bus_wr_en = en;
    @(negedge clk);
    bus_wr_stb = 1'b0; bus_wr_en = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [5:0] a, input logic [5:0] e);
    bus_addr = a;
    #1;
    chk(tag, 64'(bus_rdata), 64'(e));
  endtask

  task automatic route_chk(input string tag);
    logic ok;
    logic [5:0] c;
    logic [3:0] k;
    logic [63:0] p64;
    logic [15:0] f16;
    @(negedge clk);
    pin_in   = 46'({$urandom, $urandom});
    func_out = 12'($urandom);
    #1;
    p64 = 64'(pin_in);
    f16 = 16'({func_out, 1'b0});
    for (int i = 0; i < 8; i++) begin
      c  = m_in[i];
      ok = (c <= 6'd45) && PRESENT[c];
      // R2 / R3: live pin or idle level
      chk({tag, " R2/R3 periph_in"}, 64'(periph_in[i]), 64'(ok ? p64[c] : IDLE[i]));
    end
    for (int p = 0; p < 32; p++) begin
      k  = m_out[p];
      ok = (k != 0) && (k <= 4'd12);
      // R5 enable and data
      chk({tag, " R5 pin_oe"},  64'(pin_oe[p]),  64'(ok));
      chk({tag, " R5 pin_out"}, 64'(pin_out[p]), 64'(ok ? f16[k] : 1'b0));
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++)  m_in[i]  = 6'd63;
    for (int p = 0; p < 32; p++) m_out[p] = 4'd0;
  endtask

  task automatic reset_chk();
    for (int i = 0; i < 8; i++)  read_chk("R1 input select reset", 6'(i), 6'd63);
    for (int p = 0; p < 32; p++) read_chk("R1 output select reset", 6'(8 + p), 6'd0);
    chk("R1 periph_in idle", 64'(periph_in), 64'(IDLE));
    chk("R1 pin_oe off", 64'(pin_oe), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr_stb = 1'b0; bus_wr_en = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0; func_out = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    reset_chk();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_chk();
    route_chk("reset");

    // vector table: R7 write then readback, R6/R8 decoding
    foreach (VECS[v]) begin
      bus_write(VECS[v].addr, VECS[v].data, 1'b1);
      read_chk($sformatf("R7 R%0d readback addr %0d", VECS[v].req, VECS[v].addr),
               VECS[v].addr, VECS[v].exp);
      if (VECS[v].addr < 6'd8)       m_in[VECS[v].addr]         = VECS[v].exp;
      else if (VECS[v].addr < 6'd40) m_out[VECS[v].addr - 6'd8] = VECS[v].exp[3:0];
    end
    for (int n = 0; n < 20; n++) route_chk("random pattern");

    // R4 fan-out: inputs 0 and 1 share pin 3, pins 0 and 1 share func 1
    @(negedge clk);
    pin_in = '0; pin_in[3] = 1'b1; func_out = 12'h001;
    #1;
    chk("R4 fan-out inputs", 64'(periph_in[1:0]), 64'd3);
    chk("R4 fan-out pins", 64'(pin_out[1:0] & pin_oe[1:0]), 64'd3);
    pin_in[3] = 1'b0; func_out = 12'h000;
    #1;
    chk("R4 fan-out inputs low", 64'(periph_in[1:0]), 64'd0);
    chk("R4 fan-out pins low", 64'(pin_out[1:0]), 64'd0);

    // R7 writes dropped while write-enable is low
    bus_write(6'd0, 6'd9, 1'b0);
    read_chk("R7 gated input write", 6'd0, 6'd3);
    bus_write(6'd13, 6'd4, 1'b0);
    read_chk("R7 gated output write", 6'd13, 6'd0);
    route_chk("after gated writes");

    // R6 absent pin stays dark even after repeated writes
    bus_write(6'd39, 6'd12, 1'b1);
    read_chk("R6 absent field", 6'd39, 6'd0);
    chk("R6 absent pin oe", 64'(pin_oe[31]), 64'd0);

    // R3 reuse of a legal select after an illegal one
    bus_write(6'd3, 6'd44, 1'b1);
    m_in[3] = 6'd44;
    route_chk("R3 recovered select");

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    reset_chk();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reset_chk();
    route_chk("after second reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule